// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full 64-bit unsigned product of two 32-bit operands. It takes one bit per clock and keeps only a single double-width working register. A start pulse while the block is idle loads the operands. The multiplicand goes into its own 32-bit holding register. The multiplier goes into the low half of the working register, and the high half is cleared.

Each following cycle examines the lowest bit of the working register. When that bit is 1, the multiplicand is added into the high half by a 32-bit adder. In the same edge, the whole register moves right by one place, and the adder's carry-out enters the top bit. After 32 such steps the register holds the product: the high word in the upper half and the low word in the lower half.

A host waits for the one-cycle completion pulse and then reads the result. The result stays on the output until another start is accepted.

Top module: `seq_mul_top`

## Requirements
- R1: While reset is high at a clock edge, busy, done and product all go to 0 at that edge.
- R2: When start is high and busy is low at a rising edge, the operands are captured and busy reads 1 in the following cycle.
- R3: When an operation completes, product equals the unsigned 64-bit product of the captured multiplicand and multiplier, high word in bits 63:32.
- R4: After an accepted start, busy stays high for exactly 32 cycles, and done reads 1 in the cycle immediately after the last busy cycle.
- R5: Done is high for exactly one cycle per accepted start, and busy and done are never high together.
- R6: While the block is idle and no start is accepted, product keeps its value from one cycle to the next.
- R7: A start asserted while busy is high is ignored: neither the result nor the completion timing of the running operation changes.
- R8: A start presented in the cycle in which done is high is accepted, so operations can run back to back with no gap.
- R9: Changes on the operand inputs while busy is high have no effect on the result.
- R10: The carry out of each 32-bit addition is kept, so the largest operands give product 0xFFFFFFFE_00000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; honoured only when idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy | output | 1 | High while the 32 add/shift steps run |
| done | output | 1 | One-cycle pulse marking a valid result |
| product | output | 64 | Working register; holds the 64-bit result once done has pulsed |

## Verification
The completion pulse of one operation can fall in the same cycle as the acceptance of the next start. The bench provokes this by holding start high across the end of a run. A behavioural model decides, on every edge, whether the start was taken. The checks then require that the old result is shown during the done cycle and that busy returns on the very next cycle with a fresh 32-cycle count. Starts and operand changes injected mid-run are also checked: the model must see neither the result nor the timing disturbed.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    localparam int MUL_W = 32;
    localparam int PROD_W = 2 * MUL_W;
    localparam int STEP_CNT_W = $clog2(MUL_W);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic             carry;
        logic [MUL_W-1:0] sum;
    } add_res_t;

    function automatic logic [PROD_W-1:0] shift_in(
        input add_res_t         upper,
        input logic [MUL_W-1:0] lower
    );
        return {upper.carry, upper.sum, lower[MUL_W-1:1]};
    endfunction

endpackage

// File: rtl/seq_mul_adder.sv
module seq_mul_adder
    import seq_mul_pkg::*;
(
    input  logic [MUL_W-1:0] addend_a,
    input  logic [MUL_W-1:0] addend_b,
    input  logic             enable,
    output add_res_t         result
);
    always_comb begin
        if (enable) begin
            result = add_res_t'({1'b0, addend_a} + {1'b0, addend_b});
        end else begin
            result.carry = 1'b0;
            result.sum   = addend_a;
        end
    end
endmodule

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int STEPS = MUL_W,
    localparam int CW = $clog2(STEPS)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    mul_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          last;

    assign last = (cnt_q == CW'(STEPS - 1));
    assign load = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_RUN);
    assign busy = step;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: the completion pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: busy and done never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R2: an accepted start makes busy rise
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R4: done only follows a busy cycle
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
endmodule

// File: rtl/seq_mul_datapath.sv
module seq_mul_datapath
    import seq_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [MUL_W-1:0]  mcand_in,
    input  logic [MUL_W-1:0]  mplier_in,
    output logic [PROD_W-1:0] prod
);
    logic [MUL_W-1:0]  mcand_q;
    logic [PROD_W-1:0] prod_q;
    add_res_t          upper_next;

    seq_mul_adder u_adder (
        .addend_a (prod_q[PROD_W-1:MUL_W]),
        .addend_b (mcand_q),
        .enable   (prod_q[0]),
        .result   (upper_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{MUL_W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q <= shift_in(upper_next, prod_q[MUL_W-1:0]);
        end
    end

    assign prod = prod_q;

    // R2: the upper half starts cleared after a load
    a_r2_upper_cleared: assert property (@(posedge clk) disable iff (rst)
        load |=> (prod_q[PROD_W-1:MUL_W] == '0));

    // R9: the multiplicand copy does not move while steps run
    a_r9_mcand_frozen: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(mcand_q));
endmodule

// File: rtl/seq_mul_top.sv
module seq_mul_top
    import seq_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MUL_W-1:0]  mcand_i,
    input  logic [MUL_W-1:0]  mplier_i,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] product
);
    logic load;
    logic step;

    seq_mul_ctrl #(.STEPS(MUL_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seq_mul_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand_i),
        .mplier_in (mplier_i),
        .prod      (product)
    );

    // R6: the result holds while idle without a start
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    // R7: a start during a run does not cut it short
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |-> !load);
endmodule

// File: tb/seq_mul_top_tb_top.sv
module seq_mul_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] a_r = '0;
    logic [31:0] b_r = '0;
    logic        busy;
    logic        done;
    logic [63:0] product;

    int vectors = 0;
    int fails = 0;
    string tag = "R1";
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_mul_top dut_i (
        .clk(clk), .rst(rst), .start(start),
        .mcand_i(a_r), .mplier_i(b_r),
        .busy(busy), .done(done), .product(product)
    );

    // behavioural reference model
    bit          m_busy, m_done;
    int          m_left;
    logic [63:0] m_res, m_pend;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
            m_res <= '0; m_pend <= '0;
        end else if (!m_busy && start) begin
            m_busy <= 1'b1; m_done <= 1'b0; m_left <= 32;
            m_pend <= {32'b0, a_r} * {32'b0, b_r};
        end else if (m_busy) begin
            m_left <= m_left - 1;
            if (m_left == 1) begin
                m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend;
            end else begin
                m_done <= 1'b0;
            end
        end else begin
            m_done <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (chk_en && !finished) begin
            vectors++;
            if (busy !== m_busy) begin
                fails++;
                $display("FAIL %s busy actual=%0b expected=%0b", tag, busy, m_busy);
            end
            if (done !== m_done) begin
                fails++;
                $display("FAIL %s done actual=%0b expected=%0b", tag, done, m_done);
            end
            if (!m_busy && product !== m_res) begin
                fails++;
                $display("FAIL %s product actual=%h expected=%h", tag, product, m_res);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string t);
        tag = t;
        a_r = a; b_r = b; start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(35);
    endtask

    initial begin
        tick(2);
        chk_en = 1'b1;
        tag = "R1";
        tick(2);
        rst = 1'b0;
        tick(2);
        run_op(32'd0, 32'h1234_5678, "R3");
        run_op(32'hDEAD_BEEF, 32'd0, "R3");
        run_op(32'd1, 32'hFFFF_FFFF, "R3");
        run_op(32'd7, 32'd9, "R4");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        run_op(32'h8000_0000, 32'h8000_0001, "R10");
        for (int i = 0; i < 6; i++) run_op($urandom, $urandom, "R3");
        // R6: idle with no start, result must stay
        tag = "R6"; tick(20);
        // R7 and R9: start and operand changes mid-run
        tag = "R7";
        a_r = 32'h0001_0003; b_r = 32'h0F0F_0F0F; start = 1'b1; tick(1);
        start = 1'b0; tick(5);
        start = 1'b1; a_r = 32'hAAAA_AAAA; b_r = 32'h5555_5555; tick(3);
        start = 1'b0; tag = "R9";
        for (int i = 0; i < 10; i++) begin a_r = $urandom; b_r = $urandom; tick(1); end
        tick(20);
        // R8: start held high across done, back-to-back runs
        tag = "R8";
        a_r = 32'hCAFE_F00D; b_r = 32'h0BAD_1DEA; start = 1'b1;
        tick(34);
        a_r = 32'h1357_9BDF; b_r = 32'h2468_ACE0;
        tick(40);
        start = 1'b0; tick(40);
        // R1: reset mid-run clears everything
        tag = "R1";
        a_r = 32'h3; b_r = 32'h5; start = 1'b1; tick(1); start = 1'b0; tick(10);
        rst = 1'b1; tick(2); rst = 1'b0; tick(5);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule